// File: doc/BRIEF.md
# Exception Vectoring and Resume Unit

This unit sits beside a simple in-order pipeline. It chooses the next exception to service from two sources. The first is a synchronous request raised by the executing instruction. The second is a level-held interrupt line from an external controller that merges device interrupts onto one wire and supplies an 8-bit vector number. The chosen number k indexes a 256-word table of handler addresses held in registers, and table word k holds the entry point for exception k. Software fills the table through a word-addressed write port.

The unit also works out where the program resumes, based on the class of the event. A fault returns to the faulting instruction. A trap or an interrupt returns to the following instruction. An abort has no return point and raises an abort flag instead. A global interrupt-enable bit is cleared on entry to any handler and set again by a return-from-exception strobe.

The control is a two-state machine. `ST_IDLE` waits for a request. The transition `ACCEPT` (IDLE to ISSUE) is taken when a synchronous request is present, or when an interrupt is present and enabled. `ST_ISSUE` drives the redirect for exactly one cycle, then takes `DONE` (ISSUE to IDLE). When no request is present, `WAIT` keeps the machine in IDLE.

Top module: `exc_vector_unit`

## Requirements
- R1: On a redirect, `handler_pc` equals table word k, where k is the accepted exception number. Word k holds whatever was last written through `tbl_we`/`tbl_addr`/`tbl_data`. After reset every word is zero.
- R2: `redirect` rises in the cycle after the edge that accepts an event. It stays high for exactly one cycle, and no new event is accepted while it is high.
- R3: A synchronous request numbered 0 to 31, except 18, is a fault. For a fault, `epc` equals `cur_pc` as sampled at acceptance, and `abort` is 0. This range includes 0, 13 and 14.
- R4: A synchronous request numbered 32 to 255 is a trap. For a trap, `epc` equals `next_pc` as sampled at acceptance, and `abort` is 0.
- R5: An accepted interrupt is always of the interrupt class, whatever its number. Its `epc` equals `next_pc`, `abort` is 0, and `irq_ack` is high in the redirect cycle. `irq_ack` is never high outside a redirect.
- R6: A synchronous request numbered 18 is an abort. The redirect carries `abort`=1 and `epc`=0.
- R7: When a synchronous request and an enabled interrupt arrive in the same cycle, the synchronous one is serviced. The interrupt gets no acknowledge and stays pending.
- R8: `int_en` is cleared by every acceptance. While `int_en` is 0, the interrupt line is ignored, but synchronous requests are still accepted. A `rfe` pulse in a cycle with no acceptance sets `int_en` to 1 from the next cycle, and a pending interrupt is then taken.
- R9: After reset, `redirect`, `irq_ack` and `abort` are 0 and `int_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_req | input | 1 | Instruction raises a synchronous exception (one-cycle pulse) |
| sync_num | input | 8 | Exception number of the synchronous request |
| irq_req | input | 1 | Merged interrupt line, held until acknowledged |
| irq_num | input | 8 | Vector number supplied with the interrupt |
| cur_pc | input | 32 | PC of the instruction now executing |
| next_pc | input | 32 | PC of the instruction after it |
| rfe | input | 1 | Return-from-exception strobe |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 8 | Table word index |
| tbl_data | input | 32 | Handler address to store |
| redirect | output | 1 | One-cycle strobe: fetch from handler_pc |
| handler_pc | output | 32 | Handler entry address |
| epc | output | 32 | Saved resume PC (0 on abort) |
| abort | output | 1 | Process must be terminated |
| irq_ack | output | 1 | Interrupt taken; controller may drop the line |
| int_en | output | 1 | Global interrupt enable |

## Verification
The scoreboard runs synchronous requests at 0, 13, 14, a reserved low number, 18, and several numbers at or above 32. Comparing `epc` against distinct current and next PCs shows whether the class decode picks fault, trap or abort. An interrupt carrying number 18, and another above 32, tests whether the class comes from the source rather than the number. A same-cycle collision of a trap and an interrupt, followed by idle cycles and a return strobe, separates the priority rule, the masking, and the later service of the pending interrupt. A table rewrite between two uses of one vector shows that the lookup reads the live word.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int NUM_W = 8;
    localparam int PC_W  = 32;
    localparam logic [NUM_W-1:0] ABORT_NUM = 8'd18;
    localparam logic [NUM_W-1:0] OS_BASE   = 8'd32;

    typedef enum logic [1:0] {
        CLS_FAULT,
        CLS_TRAP,
        CLS_INTR,
        CLS_ABORT
    } exc_cls_e;

    typedef enum logic {
        ST_IDLE,
        ST_ISSUE
    } exc_state_e;

    function automatic exc_cls_e sync_class(input logic [NUM_W-1:0] n);
        if (n == ABORT_NUM)   return CLS_ABORT;
        else if (n < OS_BASE) return CLS_FAULT;
        else                  return CLS_TRAP;
    endfunction
endpackage

// File: rtl/exc_vec_table.sv
module exc_vec_table #(
    parameter int NUM_W = 8,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [NUM_W-1:0] waddr,
    input  logic [PC_W-1:0]  wdata,
    input  logic [NUM_W-1:0] raddr,
    output logic [PC_W-1:0]  rdata
);
    localparam int ENTRIES = 1 << NUM_W;

    logic [PC_W-1:0] word_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (we && (waddr == NUM_W'(g)))
                word_q[g] <= wdata;
        end
    end

    assign rdata = word_q[raddr];
endmodule

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
#(
    parameter int NW = 8,
    parameter int PW = 32
) (
    input  logic          sync_req,
    input  logic [NW-1:0] sync_num,
    input  logic          irq_req,
    input  logic [NW-1:0] irq_num,
    input  logic          int_en,
    input  logic [PW-1:0] cur_pc,
    input  logic [PW-1:0] next_pc,
    output logic          take,
    output logic          take_irq,
    output logic [NW-1:0] sel_num,
    output exc_cls_e      sel_cls,
    output logic [PW-1:0] sel_ret
);
    logic irq_live;

    assign irq_live = irq_req && int_en;
    assign take     = sync_req || irq_live;
    assign take_irq = irq_live && !sync_req;

    always_comb begin
        if (sync_req) begin
            sel_num = sync_num;
            sel_cls = sync_class(sync_num);
        end else begin
            sel_num = irq_num;
            sel_cls = CLS_INTR;
        end
        unique case (sel_cls)
            CLS_FAULT: sel_ret = cur_pc;
            CLS_TRAP,
            CLS_INTR:  sel_ret = next_pc;
            CLS_ABORT: sel_ret = '0;
        endcase
    end
endmodule

// File: rtl/exc_ctrl_fsm.sv
module exc_ctrl_fsm
    import exc_pkg::*;
#(
    parameter int NW = 8,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          take_irq,
    input  logic [NW-1:0] sel_num,
    input  exc_cls_e      sel_cls,
    input  logic [PW-1:0] sel_ret,
    input  logic          rfe,
    output logic          redirect,
    output logic [NW-1:0] cap_num,
    output logic [PW-1:0] epc,
    output logic          abort,
    output logic          irq_ack,
    output logic          int_en
);
    exc_state_e state_q, state_d;
    logic       accept;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_IDLE;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_num <= '0;
            epc     <= '0;
            abort   <= 1'b0;
            irq_ack <= 1'b0;
            int_en  <= 1'b1;
        end else begin
            irq_ack <= 1'b0;
            if (accept) begin
                cap_num <= sel_num;
                epc     <= sel_ret;
                abort   <= (sel_cls == CLS_ABORT);
                irq_ack <= take_irq;
                int_en  <= 1'b0;
            end else if (rfe) begin
                int_en  <= 1'b1;
            end
        end
    end

    assign redirect = (state_q == ST_ISSUE);
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int NW = exc_pkg::NUM_W,
    parameter int PW = exc_pkg::PC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_req,
    input  logic [NW-1:0] sync_num,
    input  logic          irq_req,
    input  logic [NW-1:0] irq_num,
    input  logic [PW-1:0] cur_pc,
    input  logic [PW-1:0] next_pc,
    input  logic          rfe,
    input  logic          tbl_we,
    input  logic [NW-1:0] tbl_addr,
    input  logic [PW-1:0] tbl_data,
    output logic          redirect,
    output logic [PW-1:0] handler_pc,
    output logic [PW-1:0] epc,
    output logic          abort,
    output logic          irq_ack,
    output logic          int_en
);
    logic          take, take_irq;
    logic [NW-1:0] sel_num, cap_num;
    exc_cls_e      sel_cls;
    logic [PW-1:0] sel_ret;

    exc_classify #(.NW(NW), .PW(PW)) u_cls (
        .sync_req (sync_req),
        .sync_num (sync_num),
        .irq_req  (irq_req),
        .irq_num  (irq_num),
        .int_en   (int_en),
        .cur_pc   (cur_pc),
        .next_pc  (next_pc),
        .take     (take),
        .take_irq (take_irq),
        .sel_num  (sel_num),
        .sel_cls  (sel_cls),
        .sel_ret  (sel_ret)
    );

    exc_ctrl_fsm #(.NW(NW), .PW(PW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_irq (take_irq),
        .sel_num  (sel_num),
        .sel_cls  (sel_cls),
        .sel_ret  (sel_ret),
        .rfe      (rfe),
        .redirect (redirect),
        .cap_num  (cap_num),
        .epc      (epc),
        .abort    (abort),
        .irq_ack  (irq_ack),
        .int_en   (int_en)
    );

    exc_vec_table #(.NUM_W(NW), .PC_W(PW)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (cap_num),
        .rdata (handler_pc)
    );
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_req,
    input logic          irq_req,
    input logic          rfe,
    input logic          redirect,
    input logic [PW-1:0] epc,
    input logic          abort,
    input logic          irq_ack,
    input logic          int_en
);
    assert_single_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    assert_abort_no_epc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && abort) |-> (epc == '0));

    assert_ack_in_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (redirect && !abort));

    assert_sync_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && sync_req && irq_req) |=> (redirect && !irq_ack));

    assert_entry_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !int_en);

    assert_rfe_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && !redirect && !sync_req && !(irq_req && int_en)) |=> int_en);
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_req (sync_req),
    .irq_req  (irq_req),
    .rfe      (rfe),
    .redirect (redirect),
    .epc      (epc),
    .abort    (abort),
    .irq_ack  (irq_ack),
    .int_en   (int_en)
);

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [31:0] hpc;
        logic [31:0] epc;
        logic        abort;
        logic        ack;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_req = 1'b0, irq_req = 1'b0, rfe = 1'b0, tbl_we = 1'b0;
    logic [7:0]  sync_num = '0, irq_num = '0, tbl_addr = '0;
    logic [31:0] cur_pc = '0, next_pc = '0, tbl_data = '0;
    logic        redirect, abort, irq_ack, int_en;
    logic [31:0] handler_pc, epc;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];
    logic [31:0] model [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_vector_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .sync_req(sync_req), .sync_num(sync_num),
        .irq_req(irq_req), .irq_num(irq_num),
        .cur_pc(cur_pc), .next_pc(next_pc), .rfe(rfe),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .redirect(redirect), .handler_pc(handler_pc), .epc(epc),
        .abort(abort), .irq_ack(irq_ack), .int_en(int_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: compare every redirect against the queue head
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (redirect) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected redirect", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(handler_pc == e.hpc, "R1", {e.req, " handler_pc"}, handler_pc, e.hpc);
                    check(epc == e.epc, e.req, "epc", epc, e.epc);
                    check(abort == e.abort, e.req, "abort", 32'(abort), 32'(e.abort));
                    check(irq_ack == e.ack, e.req, "irq_ack", 32'(irq_ack), 32'(e.ack));
                end
            end else if (irq_ack) begin
                check(1'b0, "R5", "irq_ack without redirect", 32'd1, 32'd0);
            end
        end
    end

    function automatic exp_t exp_sync(input logic [7:0] n, input logic [31:0] c,
                                      input logic [31:0] nx);
        exp_t e;
        e.hpc = model[n];
        e.ack = 1'b0;
        if (n == 8'd18)     begin e.epc = '0; e.abort = 1'b1; e.req = "R6"; end
        else if (n < 8'd32) begin e.epc = c;  e.abort = 1'b0; e.req = "R3"; end
        else                begin e.epc = nx; e.abort = 1'b0; e.req = "R4"; end
        return e;
    endfunction

    task automatic tbl_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
        model[a] = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic do_sync(input logic [7:0] n, input logic [31:0] c, input logic [31:0] nx);
        q.push_back(exp_sync(n, c, nx));
        @(negedge clk);
        sync_req = 1'b1; sync_num = n; cur_pc = c; next_pc = nx;
        @(negedge clk);
        sync_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rfe();
        @(negedge clk);
        rfe = 1'b1;
        @(negedge clk);
        rfe = 1'b0;
    endtask

    task automatic wait_ack();
        int k = 0;
        while (!irq_ack && k < 20) begin
            @(negedge clk);
            k++;
        end
        irq_req = 1'b0;
        check(k < 20, "R5", "interrupt acknowledged", 32'(k), 32'd0);
        @(negedge clk);
    endtask

    task automatic do_irq(input logic [7:0] n, input logic [31:0] c, input logic [31:0] nx);
        exp_t e;
        e.hpc = model[n]; e.epc = nx; e.abort = 1'b0; e.ack = 1'b1; e.req = "R5";
        q.push_back(e);
        @(negedge clk);
        irq_req = 1'b1; irq_num = n; cur_pc = c; next_pc = nx;
        @(negedge clk);
        wait_ack();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(redirect == 1'b0, "R9", "redirect after reset", 32'(redirect), 32'd0);
        check(irq_ack == 1'b0, "R9", "irq_ack after reset", 32'(irq_ack), 32'd0);
        check(abort == 1'b0, "R9", "abort after reset", 32'(abort), 32'd0);
        check(int_en == 1'b1, "R9", "int_en after reset", 32'(int_en), 32'd1);

        // R1: an unwritten word reads zero
        do_sync(8'd40, 32'h100, 32'h104);

        for (int i = 0; i < 256; i++) tbl_write(8'(i), 32'h8000_0000 + 32'(i) * 32'h40);

        // faults, abort, traps (R3 R4 R6)
        do_sync(8'd0,  32'h2000, 32'h2004);
        do_sync(8'd13, 32'h2100, 32'h2108);
        do_sync(8'd14, 32'h2200, 32'h2204);
        do_sync(8'd7,  32'h2300, 32'h2302);
        do_sync(8'd18, 32'h2400, 32'h2404);
        do_sync(8'd32, 32'h2500, 32'h2504);
        do_sync(8'd128, 32'h2600, 32'h2604);
        do_sync(8'd255, 32'h2700, 32'h2704);
        check(int_en == 1'b0, "R8", "int_en cleared by entry", 32'(int_en), 32'd0);

        // R1: rewrite a word then reuse it
        tbl_write(8'd14, 32'hDEAD_0000);
        do_sync(8'd14, 32'h2800, 32'h2804);

        // R8: return strobe re-enables, then interrupts (R5), class from source
        pulse_rfe();
        check(int_en == 1'b1, "R8", "int_en set by rfe", 32'(int_en), 32'd1);
        do_irq(8'd18, 32'h3000, 32'h3004);
        pulse_rfe();
        do_irq(8'd77, 32'h3100, 32'h3104);

        // R7: collision, interrupt stays pending and masked (R8)
        pulse_rfe();
        q.push_back(exp_sync(8'd40, 32'h4000, 32'h4004));
        @(negedge clk);
        sync_req = 1'b1; sync_num = 8'd40; cur_pc = 32'h4000; next_pc = 32'h4004;
        irq_req = 1'b1;  irq_num = 8'd50;
        @(negedge clk);
        sync_req = 1'b0;
        repeat (6) @(negedge clk);
        check(int_en == 1'b0, "R8", "interrupt masked after entry", 32'(int_en), 32'd0);
        check(q.size() == 0, "R7", "no extra redirect while pending", 32'(q.size()), 32'd0);
        // R8: synchronous still taken while masked
        do_sync(8'd13, 32'h4100, 32'h4104);
        begin
            exp_t e;
            e.hpc = model[50]; e.epc = 32'h5004; e.abort = 1'b0; e.ack = 1'b1; e.req = "R7";
            q.push_back(e);
        end
        cur_pc = 32'h5000; next_pc = 32'h5004;
        pulse_rfe();
        wait_ack();

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R2", "all expected redirects seen", 32'(q.size()), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule